// File: doc/BRIEF.md
# Region History Buffer with Trigger Index

This block keeps a running log of spatial region records and lets a later stage find where a given region was last recorded. Each record has three parts: a trigger address, a small bit vector for the instruction blocks before the trigger, and a wider bit vector for the blocks after it. Records arrive from an upstream compactor and are appended to a circular buffer at its tail. An index table maps the block-aligned trigger address to the buffer position of that trigger's newest record.

A stream engine downstream sends a candidate address to the lookup port. One cycle later it gets a hit flag and a buffer position. It can then read any record through a combinational read port and walk forward through the log from that position. The index is fully associative. It uses free entries first, then replaces the least recently used entry. Both a record write and a lookup hit refresh an entry's recency. A trigger that is written again moves its existing pointer to the new position; no second entry is created for it.

Top module: `region_history_index`

## Requirements
- R1: After reset the write position is 0, every index entry is empty, and `lk_resp_valid` is low until a lookup is issued.
- R2: A record written while `wr_valid` is high is stored at the current tail position. The tail advances by one only on a write. From the following cycle, `rd_trigger` returns the stored block-aligned trigger with bits below the block offset at 0, and `rd_prec` and `rd_succ` return the stored vectors for `rd_ptr` equal to that position.
- R3: After a write at position `LOG_DEPTH-1` the tail returns to 0, so the next record overwrites the oldest slot.
- R4: A lookup issued with `lk_valid` is answered in the next cycle with `lk_resp_valid` high. If the trigger's block is indexed, `lk_hit` is 1 and `lk_ptr` is the position of that trigger's newest record.
- R5: Writing a trigger that is already indexed moves its pointer to the new write position and takes no further index entry.
- R6: A lookup of a block that is not indexed returns `lk_hit` 0 and `lk_ptr` 0. When no lookup was issued, `lk_hit` is 0.
- R7: Index matching uses the address bits above the block offset (`BLK_OFF`) only. Two addresses in the same block match whatever their low bits.
- R8: While any index entry is empty, a new trigger takes an empty entry and no indexed trigger is lost.
- R9: When every entry is in use, a new trigger replaces the entry that was used least recently. A later lookup of the replaced trigger misses.
- R10: A lookup hit makes the entry the most recently used, so that entry survives the next replacement.
- R11: When a write and a lookup arrive in the same cycle, the write takes effect first. A lookup of the trigger being written hits with the position being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Append a record this cycle |
| wr_trigger | input | ADDR_W | Trigger address of the record |
| wr_prec | input | PREC_W | Preceding-block vector |
| wr_succ | input | SUCC_W | Succeeding-block vector |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Address to look up |
| lk_resp_valid | output | 1 | Lookup answer present (one cycle after request) |
| lk_hit | output | 1 | Lookup found the block in the index |
| lk_ptr | output | PTR_W | Buffer position of the newest record for the block, 0 on miss |
| rd_ptr | input | PTR_W | Buffer position to read |
| rd_trigger | output | ADDR_W | Block-aligned trigger stored at `rd_ptr` |
| rd_prec | output | PREC_W | Preceding-block vector stored at `rd_ptr` |
| rd_succ | output | SUCC_W | Succeeding-block vector stored at `rd_ptr` |

## Verification
The assertions check the following on every cycle:
- the tail step and wrap (R2, R3);
- the one-cycle timing of lookup answers (R4);
- the zero pointer on a miss (R6);
- write-before-lookup ordering when a write and a lookup name the same block in one cycle (R11).

Replacement order, pointer refresh and block-offset masking depend on long histories of writes and lookups. Only the bench scenarios show them, by comparing answers with a reference model that orders entries by last-use timestamps. Directed sequences fill the index, then force evictions right after recency-changing hits. These cover the free-entry rule and both sides of the replacement choice.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  localparam int unsigned DEF_ADDR_W      = 32;
  localparam int unsigned DEF_BLK_OFF     = 6;
  localparam int unsigned DEF_PREC_W      = 2;
  localparam int unsigned DEF_SUCC_W      = 8;
  localparam int unsigned DEF_LOG_DEPTH   = 16;
  localparam int unsigned DEF_IDX_ENTRIES = 64;

  // How a record write lands in the index
  typedef enum logic [1:0] {
    SLOT_NONE    = 2'd0,
    SLOT_REFRESH = 2'd1,
    SLOT_FILL    = 2'd2,
    SLOT_EVICT   = 2'd3
  } slot_kind_e;
endpackage

// File: rtl/rhb_log.sv
// Circular record log: write at tail, combinational read by position.
module rhb_log #(
  parameter int unsigned TAG_W  = 26,
  parameter int unsigned PREC_W = 2,
  parameter int unsigned SUCC_W = 8,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [PREC_W-1:0] wr_prec,
  input  logic [SUCC_W-1:0] wr_succ,
  output logic [PTR_W-1:0]  tail,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [PREC_W-1:0] rd_prec,
  output logic [SUCC_W-1:0] rd_succ
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  tail_q, tail_d;
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [PREC_W-1:0] prec_mem [DEPTH];
  logic [SUCC_W-1:0] succ_mem [DEPTH];

  always_comb begin
    tail_d = tail_q;
    if (wr_en) begin
      tail_d = (tail_q == LAST) ? '0 : tail_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
    end else if (wr_en) begin
      tail_q <= tail_d;
    end
  end

  // Storage carries no reset; unwritten slots are never pointed at by the index
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[tail_q]  <= wr_tag;
      prec_mem[tail_q] <= wr_prec;
      succ_mem[tail_q] <= wr_succ;
    end
  end

  assign tail    = tail_q;
  assign rd_tag  = tag_mem[rd_ptr];
  assign rd_prec = prec_mem[rd_ptr];
  assign rd_succ = succ_mem[rd_ptr];
endmodule

// File: rtl/rhb_index.sv
// Fully associative trigger index with age-rank LRU and write-first lookup.
module rhb_index
  import rhb_pkg::*;
#(
  parameter int unsigned TAG_W   = 26,
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned PTR_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic [PTR_W-1:0] upd_ptr,
  input  logic             lk_en,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PTR_W-1:0] lk_ptr
);
  localparam int unsigned AGE_W  = $clog2(ENTRIES);
  localparam int unsigned SLOT_W = AGE_W;
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

  typedef logic [ENTRIES-1:0][AGE_W-1:0] age_vec_t;

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q [ENTRIES];
  age_vec_t           age_q, age_mid, age_d;
  logic               age_en;

  logic              upd_hit, free_any;
  logic [SLOT_W-1:0] upd_hit_idx, free_idx, lru_idx, upd_slot;
  slot_kind_e        upd_kind;

  logic              lk_raw_hit, lk_fwd, lk_clobbered;
  logic [SLOT_W-1:0] lk_raw_idx, lk_slot;
  logic [PTR_W-1:0]  lk_ptr_sel;

  // Age 0 is most recent; the touched entry goes to 0 and younger ones age by one
  function automatic age_vec_t promote(input age_vec_t a, input logic [SLOT_W-1:0] k);
    age_vec_t r;
    for (int j = 0; j < ENTRIES; j++) begin
      if (j == int'(k))       r[j] = '0;
      else if (a[j] < a[k])   r[j] = a[j] + 1'b1;
      else                    r[j] = a[j];
    end
    return r;
  endfunction

  // Write-side search: existing entry, lowest free entry, oldest entry
  always_comb begin
    upd_hit     = 1'b0;
    upd_hit_idx = '0;
    free_any    = 1'b0;
    free_idx    = '0;
    lru_idx     = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vld_q[i] && (tag_q[i] == upd_tag)) begin
        upd_hit     = 1'b1;
        upd_hit_idx = SLOT_W'(i);
      end
      if (!vld_q[i]) begin
        free_any = 1'b1;
        free_idx = SLOT_W'(i);
      end
      if (age_q[i] == OLDEST) begin
        lru_idx = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    if (!upd_en)       upd_kind = SLOT_NONE;
    else if (upd_hit)  upd_kind = SLOT_REFRESH;
    else if (free_any) upd_kind = SLOT_FILL;
    else               upd_kind = SLOT_EVICT;

    unique case (upd_kind)
      SLOT_REFRESH: upd_slot = upd_hit_idx;
      SLOT_FILL:    upd_slot = free_idx;
      SLOT_EVICT:   upd_slot = lru_idx;
      default:      upd_slot = '0;
    endcase
  end

  // Lookup-side search against current contents
  always_comb begin
    lk_raw_hit = 1'b0;
    lk_raw_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vld_q[i] && (tag_q[i] == lk_tag)) begin
        lk_raw_hit = 1'b1;
        lk_raw_idx = SLOT_W'(i);
      end
    end
  end

  // Write-first: forward a same-block write, drop an entry being retagged
  always_comb begin
    lk_fwd       = upd_en && (upd_tag == lk_tag);
    lk_clobbered = upd_en && lk_raw_hit && (lk_raw_idx == upd_slot);
    lk_hit       = lk_en && (lk_fwd || (lk_raw_hit && !lk_clobbered));
    lk_slot      = lk_fwd ? upd_slot : lk_raw_idx;
    lk_ptr_sel   = lk_fwd ? upd_ptr  : ptr_q[lk_raw_idx];
    lk_ptr       = lk_hit ? lk_ptr_sel : '0;
  end

  // Recency: write touch first, lookup touch last
  always_comb begin
    age_mid = upd_en ? promote(age_q, upd_slot) : age_q;
    age_d   = lk_hit ? promote(age_mid, lk_slot) : age_mid;
    age_en  = upd_en || lk_hit;
    vld_d   = vld_q;
    if (upd_en) vld_d[upd_slot] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        age_q[i] <= AGE_W'(i);
      end
    end else begin
      if (upd_en) vld_q <= vld_d;
      if (age_en) age_q <= age_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      tag_q[upd_slot] <= upd_tag;
      ptr_q[upd_slot] <= upd_ptr;
    end
  end
endmodule

// File: rtl/region_history_index.sv
module region_history_index
  import rhb_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned BLK_OFF     = DEF_BLK_OFF,
  parameter int unsigned PREC_W      = DEF_PREC_W,
  parameter int unsigned SUCC_W      = DEF_SUCC_W,
  parameter int unsigned LOG_DEPTH   = DEF_LOG_DEPTH,
  parameter int unsigned IDX_ENTRIES = DEF_IDX_ENTRIES,
  parameter int unsigned PTR_W       = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_trigger,
  input  logic [PREC_W-1:0] wr_prec,
  input  logic [SUCC_W-1:0] wr_succ,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_resp_valid,
  output logic              lk_hit,
  output logic [PTR_W-1:0]  lk_ptr,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [ADDR_W-1:0] rd_trigger,
  output logic [PREC_W-1:0] rd_prec,
  output logic [SUCC_W-1:0] rd_succ
);
  localparam int unsigned TAG_W = ADDR_W - BLK_OFF;

  logic [TAG_W-1:0]   wr_tag, lk_tag, rd_tag;
  logic [PTR_W-1:0]   log_tail;
  logic               idx_hit;
  logic [PTR_W-1:0]   idx_ptr;
  logic               resp_valid_q, resp_valid_d;
  logic               hit_q, hit_d;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               offset_unused;

  assign wr_tag        = wr_trigger[ADDR_W-1:BLK_OFF];
  assign lk_tag        = lk_addr[ADDR_W-1:BLK_OFF];
  assign offset_unused = ^{wr_trigger[BLK_OFF-1:0], lk_addr[BLK_OFF-1:0]};

  rhb_log #(
    .TAG_W (TAG_W),
    .PREC_W(PREC_W),
    .SUCC_W(SUCC_W),
    .DEPTH (LOG_DEPTH),
    .PTR_W (PTR_W)
  ) u_log (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_valid),
    .wr_tag (wr_tag),
    .wr_prec(wr_prec),
    .wr_succ(wr_succ),
    .tail   (log_tail),
    .rd_ptr (rd_ptr),
    .rd_tag (rd_tag),
    .rd_prec(rd_prec),
    .rd_succ(rd_succ)
  );

  rhb_index #(
    .TAG_W  (TAG_W),
    .ENTRIES(IDX_ENTRIES),
    .PTR_W  (PTR_W)
  ) u_index (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (wr_valid),
    .upd_tag(wr_tag),
    .upd_ptr(log_tail),
    .lk_en  (lk_valid),
    .lk_tag (lk_tag),
    .lk_hit (idx_hit),
    .lk_ptr (idx_ptr)
  );

  always_comb begin
    resp_valid_d = lk_valid;
    hit_d        = idx_hit;
    ptr_d        = idx_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      hit_q        <= 1'b0;
      ptr_q        <= '0;
    end else begin
      resp_valid_q <= resp_valid_d;
      hit_q        <= hit_d;
      ptr_q        <= ptr_d;
    end
  end

  assign lk_resp_valid = resp_valid_q;
  assign lk_hit        = hit_q;
  assign lk_ptr        = ptr_q;
  assign rd_trigger    = {rd_tag, {BLK_OFF{1'b0}}};
endmodule

// File: rtl/rhb_checker.sv
module rhb_checker #(
  parameter int unsigned TAG_W     = 26,
  parameter int unsigned LOG_DEPTH = 16,
  parameter int unsigned PTR_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic [TAG_W-1:0] wr_tag,
  input logic             lk_valid,
  input logic [TAG_W-1:0] lk_tag,
  input logic             lk_resp_valid,
  input logic             lk_hit,
  input logic [PTR_W-1:0] lk_ptr,
  input logic [PTR_W-1:0] tail
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(LOG_DEPTH - 1);

  AST_TAIL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && tail != LAST) |=> (tail == PTR_W'($past(tail) + 1'b1))); // R2
  AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(tail)); // R2
  AST_TAIL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && tail == LAST) |=> (tail == '0)); // R3
  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_resp_valid); // R4
  AST_RESP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!lk_resp_valid && !lk_hit)); // R6
  AST_MISS_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ptr == '0)); // R6
  AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && lk_valid && wr_tag == lk_tag) |=> (lk_hit && lk_ptr == $past(tail))); // R11
endmodule

bind region_history_index rhb_checker #(
  .TAG_W    (ADDR_W - BLK_OFF),
  .LOG_DEPTH(LOG_DEPTH),
  .PTR_W    (PTR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_tag       (wr_tag),
  .lk_valid     (lk_valid),
  .lk_tag       (lk_tag),
  .lk_resp_valid(lk_resp_valid),
  .lk_hit       (lk_hit),
  .lk_ptr       (lk_ptr),
  .tail         (log_tail)
);

// File: tb/region_history_index_tb.sv
module region_history_index_tb;
  localparam int AW = 32, BO = 6, PW = 2, SW = 8, DEPTH = 16, ENT = 64, TW = AW - BO;

  logic clk, rst_n;
  logic wr_valid, lk_valid;
  logic [AW-1:0] wr_trigger, lk_addr;
  logic [PW-1:0] wr_prec;
  logic [SW-1:0] wr_succ;
  logic lk_resp_valid, lk_hit;
  logic [3:0] lk_ptr, rd_ptr;
  logic [AW-1:0] rd_trigger;
  logic [PW-1:0] rd_prec;
  logic [SW-1:0] rd_succ;

  region_history_index u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_trigger(wr_trigger),
    .wr_prec(wr_prec), .wr_succ(wr_succ), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_resp_valid(lk_resp_valid), .lk_hit(lk_hit), .lk_ptr(lk_ptr),
    .rd_ptr(rd_ptr), .rd_trigger(rd_trigger), .rd_prec(rd_prec), .rd_succ(rd_succ)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // Reference model: log plus index ordered by last-use stamps
  logic [TW-1:0] hb_tag [DEPTH];
  logic [PW-1:0] hb_prec[DEPTH];
  logic [SW-1:0] hb_succ[DEPTH];
  bit            hb_ok  [DEPTH];
  int            m_tail;
  bit            ix_v   [ENT];
  logic [TW-1:0] ix_tag [ENT];
  int            ix_ptr [ENT];
  longint        ix_use [ENT];
  longint        use_ctr;

  bit    pend_lk;
  bit    pend_hit;
  int    pend_ptr;
  string pend_req;
  int    cur_rp;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_write(input logic [TW-1:0] t, input logic [PW-1:0] p, input logic [SW-1:0] s);
    int k;
    hb_tag[m_tail] = t; hb_prec[m_tail] = p; hb_succ[m_tail] = s; hb_ok[m_tail] = 1'b1;
    k = -1;
    for (int i = 0; i < ENT; i++) if (k < 0 && ix_v[i] && ix_tag[i] == t) k = i;
    for (int i = 0; i < ENT; i++) if (k < 0 && !ix_v[i]) k = i;
    if (k < 0) begin
      k = 0;
      for (int i = 1; i < ENT; i++) if (ix_use[i] < ix_use[k]) k = i;
    end
    use_ctr++;
    ix_v[k] = 1'b1; ix_tag[k] = t; ix_ptr[k] = m_tail; ix_use[k] = use_ctr;
    m_tail = (m_tail + 1) % DEPTH;
  endtask

  task automatic model_lookup(input logic [TW-1:0] t, output bit h, output int p);
    h = 1'b0; p = 0;
    for (int i = 0; i < ENT; i++) begin
      if (!h && ix_v[i] && ix_tag[i] == t) begin
        h = 1'b1; p = ix_ptr[i]; use_ctr++; ix_use[i] = use_ctr;
      end
    end
  endtask

  task automatic step(input bit w, input logic [AW-1:0] wa, input logic [PW-1:0] wp,
                      input logic [SW-1:0] ws, input bit l, input logic [AW-1:0] la,
                      input int rp, input string req);
    bit h; int p;
    @(negedge clk);
    if (pend_lk) begin
      chk(pend_req, "lk_resp_valid", lk_resp_valid, 1);
      chk(pend_req, "lk_hit", lk_hit, pend_hit);
      chk(pend_req, "lk_ptr", lk_ptr, pend_ptr);
    end
    if (hb_ok[cur_rp]) begin
      chk("R2", "rd_trigger", rd_trigger, {hb_tag[cur_rp], 6'b0});
      chk("R2", "rd_prec", rd_prec, hb_prec[cur_rp]);
      chk("R2", "rd_succ", rd_succ, hb_succ[cur_rp]);
    end
    wr_valid = w; wr_trigger = wa; wr_prec = wp; wr_succ = ws;
    lk_valid = l; lk_addr = la; rd_ptr = 4'(rp);
    if (w) model_write(wa[AW-1:BO], wp, ws);
    if (l) begin
      model_lookup(la[AW-1:BO], h, p);
      pend_hit = h; pend_ptr = p;
    end
    pend_lk = l; pend_req = req; cur_rp = rp;
  endtask

  task automatic wr(input logic [AW-1:0] a, input string req);
    step(1'b1, a, 2'(a >> 6), 8'(a >> 8), 1'b0, '0, cur_rp, req);
  endtask

  task automatic lk(input logic [AW-1:0] a, input string req);
    step(1'b0, '0, '0, '0, 1'b1, a, cur_rp, req);
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) hb_ok[i] = 1'b0;
    for (int i = 0; i < ENT; i++) begin ix_v[i] = 1'b0; ix_use[i] = 0; end
    m_tail = 0; use_ctr = 0; pend_lk = 1'b0; cur_rp = 0; pend_req = "";
    rst_n = 1'b0; wr_valid = 1'b0; lk_valid = 1'b0;
    wr_trigger = '0; lk_addr = '0; wr_prec = '0; wr_succ = '0; rd_ptr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "lk_resp_valid idle", lk_resp_valid, 0);

    // R1: empty index after reset
    lk(32'h0000_4000, "R1");
    // R2/R7: first record at position 0, trigger with offset bits set
    step(1'b1, 32'h0000_1008, 2'b01, 8'h81, 1'b0, '0, 0, "R2");
    lk(32'h0000_103C, "R7");
    lk(32'h0000_1040, "R6");
    // R3: 16 more records; the last lands at position 0
    for (int i = 0; i < 16; i++) wr(32'h0000_2000 + i * 64, "R3");
    lk(32'h0000_2000 + 15 * 64, "R3");
    step(1'b0, '0, '0, '0, 1'b0, '0, 0, "R3");
    // R5: rewrite an indexed trigger
    wr(32'h0000_1010, "R5");
    lk(32'h0000_1000, "R5");
    // R11: write and lookup of one block in the same cycle
    step(1'b1, 32'h0000_9004, 2'b10, 8'h3C, 1'b1, 32'h0000_9030, 1, "R11");
    lk(32'h0007_7000, "R6");
    // R8: reach 64 distinct triggers; early untouched entry still indexed
    for (int i = 0; i < 46; i++) wr(32'h0004_0000 + i * 64, "R8");
    lk(32'h0000_2000, "R8");
    // R9/R10: refill with a fresh set, then refresh the oldest before evicting
    for (int i = 0; i < 64; i++) wr(32'h0008_0000 + i * 64, "R9");
    lk(32'h0008_0000, "R10");
    wr(32'h000C_0000, "R9");
    lk(32'h0008_0040, "R9");
    lk(32'h0008_0000, "R10");
    lk(32'h000C_0000, "R4");

    // Random phase over a pool larger than the index
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] wa, la;
      wa = ((32'h300 + $urandom_range(0, 95)) << 6) | $urandom_range(0, 63);
      la = ((32'h300 + $urandom_range(0, 95)) << 6) | $urandom_range(0, 63);
      step(1'($urandom_range(0, 1)), wa, 2'($urandom), 8'($urandom),
           1'($urandom_range(0, 1)), la, $urandom_range(0, DEPTH - 1), "R4");
    end
    step(1'b0, '0, '0, '0, 1'b0, '0, cur_rp, "R4");
    step(1'b0, '0, '0, '0, 1'b0, '0, cur_rp, "R4");
    summary();
    $finish;
  end
endmodule